// File: doc/BRIEF.md
# Bus-Attached Serial Port with Error Status and Interrupt

This block is a single-channel asynchronous serial port that a processor reaches through a simple word-addressed register bus. Software writes a byte into a one-deep transmit holding slot. The block moves that byte into a shift register and sends it as an 8N1 frame, least significant bit first. In the other direction, the block captures incoming frames into a one-deep receive slot. A programmable divisor sets the bit period as a number of clock cycles.

A status word reports the ready flags, the line errors and the clear-to-send input. Software clears all the sticky error flags with any write to the status word. A control word holds one interrupt enable per status flag, at the same bit position as that flag. It also holds a transmit-break force and the request-to-send output level. The block drives a single level-sensitive interrupt line.

The word index on the bus is the byte offset divided by four. The registers are: 0 receive data, 1 transmit data, 2 status, 3 control, 4 divisor and 5 packet-end character. The packet-end character is stored and read back only; status bit 12 always reads 0.

Top module: `mmio_uart`

## Requirements
- R1: After reset, control and the sticky flags are 0, irq is 0, txd is 1, rts_out is 0, status reads 0x0060 while cts_in is low, and the divisor reads DIV_INIT.
- R2: Control (index 3, 13 bits), divisor (index 4) and packet-end character (index 5, 8 bits) read back the value last written.
- R3: A byte accepted into the holding slot goes out on txd one clock after the shifter is free. The frame is one low start bit, eight data bits LSB first and one high stop bit, each lasting divisor clocks. txd is 1 when idle.
- R4: Status bit 6 (tx ready) is low exactly while the holding slot is occupied. Status bit 5 (transmitter empty) is high only when both the holding slot and the shifter are empty.
- R5: A write to transmit data while bit 6 is low sets status bit 4 (tx overrun), and that byte is never sent.
- R6: While control bit 9 is set, txd is held low.
- R7: A received frame with a high stop bit loads receive data and sets status bit 7. A read of index 0 returns the byte and clears bit 7.
- R8: A frame that completes while bit 7 is still set sets status bit 3 (rx overrun), and the new byte replaces the old one.
- R9: A frame whose stop bit is low sets status bit 1 (framing). If its eight data bits are also all zero, it sets status bit 2 (break) as well.
- R10: Status bit 8 is the OR of status bits 0 to 4.
- R11: Any write to status clears bits 0 to 4 and bit 10, and leaves bit 7 unchanged.
- R12: cts_in passes through two flops before it appears as status bit 11. Either edge of the synchronized level sets sticky status bit 10.
- R13: irq is high exactly when some status bit in positions 0 to 8, 10 or 12 is set together with the control bit at the same position. Control bits 9 and 11 never raise irq.
- R14: rts_out follows control bit 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; only index 0 has a side effect |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| rts_out | output | 1 | Request-to-send output |

## Verification
The bench builds the port with DIV_INIT = 10, which it can tell apart from the default, so the reset value of the divisor is checked directly. It then programs a divisor of 6. Bits that short let back-to-back transmit frames, a write dropped on a full slot, and two received frames overrunning each other all run within a few hundred clocks. An even divisor also puts the receiver's mid-bit sample squarely inside each bit the bench drives. The bench keeps its own model of the transmit slot, the shifter and the break force as counters. Against that model it compares txd, tx ready, transmitter empty and tx overrun on every idle bus cycle.

// File: rtl/mmio_uart_pkg.sv
`timescale 1ns/1ps
package mmio_uart_pkg;

  localparam int ADDR_W = 3;
  localparam int CTRL_W = 13;

  typedef enum logic [ADDR_W-1:0] {
    RA_RXDATA  = 3'd0,
    RA_TXDATA  = 3'd1,
    RA_STATUS  = 3'd2,
    RA_CONTROL = 3'd3,
    RA_DIVISOR = 3'd4,
    RA_PKTEND  = 3'd5
  } reg_addr_e;

  // control positions that act as interrupt enables (0..8, 10, 12)
  localparam logic [CTRL_W-1:0] IRQ_EN_MASK = 13'h15FF;
  localparam int CB_BREAK = 9;
  localparam int CB_RTS   = 11;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLDLOW
  } rx_state_e;

  // last clock of a full bit period
  function automatic logic bit_last(input logic [31:0] cnt, input logic [31:0] div);
    return (cnt + 32'd1) >= div;
  endfunction

  // clocks from start edge to start-bit centre, never below one
  function automatic logic [31:0] half_len(input logic [31:0] div);
    return ((div >> 1) == 32'd0) ? 32'd1 : (div >> 1);
  endfunction

  function automatic logic mid_last(input logic [31:0] cnt, input logic [31:0] div);
    return (cnt + 32'd1) >= half_len(div);
  endfunction

endpackage

// File: rtl/mmio_uart_sync.sv
`timescale 1ns/1ps
module mmio_uart_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mmio_uart_tx.sv
`timescale 1ns/1ps
module mmio_uart_tx
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hold_full,
  output logic              busy,
  output logic              line,
  output logic              overrun_evt
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic               start;

  assign start       = !busy && hold_full;
  assign overrun_evt = wr_strobe && hold_full;
  assign line        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (start) hold_full <= 1'b0;
      if (wr_strobe && !hold_full) begin
        hold_full <= 1'b1;
        hold_q    <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      bitn  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      shreg <= {1'b1, hold_q, 1'b0};
      cnt   <= '0;
      bitn  <= '0;
    end else if (busy) begin
      if (bit_last(32'(cnt), 32'(div))) begin
        cnt <= '0;
        if (bitn == BIT_W'(FRAME_W - 1)) begin
          busy <= 1'b0;
        end else begin
          bitn  <= bitn + 1'b1;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmio_uart_rx.sv
`timescale 1ns/1ps
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_s,
  output logic              done,
  output logic [DATA_W-1:0] data_out,
  output logic              stop_bit
);
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_e         state;
  logic [DIV_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] sh;

  assign done     = (state == RX_STOP) && bit_last(32'(cnt), 32'(div));
  assign data_out = sh;
  assign stop_bit = rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!rx_s) state <= RX_START;
        end
        RX_START: begin
          if (mid_last(32'(cnt), 32'(div))) begin
            cnt   <= '0;
            bitn  <= '0;
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (bit_last(32'(cnt), 32'(div))) begin
            cnt <= '0;
            sh  <= {rx_s, sh[DATA_W-1:1]};
            if (bitn == BIT_W'(DATA_W - 1)) state <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (bit_last(32'(cnt), 32'(div))) begin
            cnt   <= '0;
            state <= rx_s ? RX_IDLE : RX_HOLDLOW;
          end else cnt <= cnt + 1'b1;
        end
        RX_HOLDLOW: if (rx_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart.sv
`timescale 1ns/1ps
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int DIV_W    = 16,
  parameter int DIV_INIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts_in,
  output logic              rts_out
);
  localparam int DATA_W = 8;

  // bus decode
  logic wr_tx, wr_st, wr_ctrl, wr_div, wr_pkt, rd_rx;
  assign wr_tx   = bus_wr && (bus_addr == RA_TXDATA);
  assign wr_st   = bus_wr && (bus_addr == RA_STATUS);
  assign wr_ctrl = bus_wr && (bus_addr == RA_CONTROL);
  assign wr_div  = bus_wr && (bus_addr == RA_DIVISOR);
  assign wr_pkt  = bus_wr && (bus_addr == RA_PKTEND);
  assign rd_rx   = bus_rd && (bus_addr == RA_RXDATA);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CTRL_W];

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_INIT);
      pkt_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_pkt)  pkt_q  <= bus_wdata[DATA_W-1:0];
    end
  end

  // synchronizers and named events
  logic rx_s, cts_s, cts_prev, cts_edge;
  mmio_uart_sync #(.RST_VAL(1'b1)) u_rx_sync  (.clk(clk), .rst_n(rst_n), .d(rxd),    .q(rx_s));
  mmio_uart_sync #(.RST_VAL(1'b0)) u_cts_sync (.clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_prev <= 1'b0;
    else        cts_prev <= cts_s;
  end
  assign cts_edge = cts_s ^ cts_prev;

  // transmitter
  logic tx_hold_full, tx_busy, tx_line, tx_overrun;
  mmio_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q),
    .wr_strobe(wr_tx), .wr_data(bus_wdata[DATA_W-1:0]),
    .hold_full(tx_hold_full), .busy(tx_busy), .line(tx_line),
    .overrun_evt(tx_overrun)
  );
  assign txd     = ctrl_q[CB_BREAK] ? 1'b0 : tx_line;
  assign rts_out = ctrl_q[CB_RTS];

  // receiver
  logic              rx_done, rx_stop;
  logic [DATA_W-1:0] rx_byte;
  mmio_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .rx_s(rx_s),
    .done(rx_done), .data_out(rx_byte), .stop_bit(rx_stop)
  );

  // receive slot and sticky flags
  logic [DATA_W-1:0] rxbuf;
  logic rrdy, err_fe, err_brk, err_roe, err_toe, cts_chg;
  logic err_pe;
  assign err_pe = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf   <= '0;
      rrdy    <= 1'b0;
      err_fe  <= 1'b0;
      err_brk <= 1'b0;
      err_roe <= 1'b0;
      err_toe <= 1'b0;
      cts_chg <= 1'b0;
    end else begin
      if (wr_st) begin
        err_fe  <= 1'b0;
        err_brk <= 1'b0;
        err_roe <= 1'b0;
        err_toe <= 1'b0;
        cts_chg <= 1'b0;
      end
      if (tx_overrun) err_toe <= 1'b1;
      if (cts_edge)   cts_chg <= 1'b1;
      if (rx_done) begin
        rxbuf <= rx_byte;
        rrdy  <= 1'b1;
        if (rrdy && !rd_rx) err_roe <= 1'b1;
        if (!rx_stop) err_fe <= 1'b1;
        if (!rx_stop && (rx_byte == '0)) err_brk <= 1'b1;
      end else if (rd_rx) begin
        rrdy <= 1'b0;
      end
    end
  end

  // status word
  logic              exc;
  logic [CTRL_W-1:0] status_w;
  assign exc = err_pe | err_fe | err_brk | err_roe | err_toe;
  assign status_w = {1'b0, cts_s, cts_chg, 1'b0, exc, rrdy,
                     !tx_hold_full, !tx_hold_full && !tx_busy,
                     err_toe, err_roe, err_brk, err_fe, err_pe};

  assign irq = |(status_w & ctrl_q & IRQ_EN_MASK);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_RXDATA:  bus_rdata = BUS_W'(rxbuf);
      RA_STATUS:  bus_rdata = BUS_W'(status_w);
      RA_CONTROL: bus_rdata = BUS_W'(ctrl_q);
      RA_DIVISOR: bus_rdata = BUS_W'(div_q);
      RA_PKTEND:  bus_rdata = BUS_W'(pkt_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmio_uart_chk.sv
`timescale 1ns/1ps
module mmio_uart_chk
  import mmio_uart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              txd,
  input logic              irq,
  input logic [CTRL_W-1:0] status_w,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              rx_done,
  input logic              cts_edge,
  input logic              tx_busy
);
  logic tx_write, st_write, rx_read;
  assign tx_write = bus_wr && (bus_addr == 3'd1);
  assign st_write = bus_wr && (bus_addr == 3'd2);
  assign rx_read  = bus_rd && (bus_addr == 3'd0);

  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !ctrl_q[9]) |-> txd);

  a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[9] |-> !txd);

  a_r4_empty_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[5] |-> status_w[6]);

  a_r5_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !status_w[6]) |=> status_w[4]);

  a_r7_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !rx_done) |=> !status_w[7]);

  a_r11_status_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_write && !rx_done && !cts_edge) |=> (status_w[4:0] == 5'd0 && !status_w[10]));

  a_r12_cts_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cts_edge |=> status_w[10]);

  a_r13_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & 13'h15FF) == 13'd0) |-> !irq);
endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .txd(txd), .irq(irq), .status_w(status_w), .ctrl_q(ctrl_q),
  .rx_done(rx_done), .cts_edge(cts_edge), .tx_busy(tx_busy)
);

// File: tb/mmio_uart_tb.sv
`timescale 1ns/1ps
module mmio_uart_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, txd, rxd, cts_in, rts_out;

  always #2.5 clk = ~clk;

  mmio_uart #(.BUS_W(16), .DIV_W(16), .DIV_INIT(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .txd(txd), .rxd(rxd),
    .cts_in(cts_in), .rts_out(rts_out)
  );

  int nchk = 0, nbad = 0;
  bit finished = 0;
  bit cmp_on = 0;
  int bdiv = 10;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of the transmit side
  bit        m_hold, m_busy, m_toe, m_brk, h0;
  int        m_pos, m_div, m_fdiv;
  logic [7:0] m_hbyte;
  logic [9:0] m_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_busy = 0; m_toe = 0; m_brk = 0; m_pos = 0; m_div = 10; m_fdiv = 10;
    end else begin
      h0 = m_hold;
      if (m_busy) begin
        m_pos++;
        if (m_pos == 10 * m_fdiv) m_busy = 0;
      end else if (m_hold) begin
        m_busy = 1; m_pos = 0; m_fdiv = m_div; m_hold = 0;
        m_frame = {1'b1, m_hbyte, 1'b0};
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd1: if (h0) m_toe = 1; else begin m_hold = 1; m_hbyte = bus_wdata[7:0]; end
          3'd2: m_toe = 0;
          3'd3: m_brk = bus_wdata[9];
          3'd4: m_div = int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_on && bus_addr == 3'd2 && !bus_wr && !bus_rd && !finished) begin
      check("R3/R6 txd", txd, m_brk ? 0 : (m_busy ? m_frame[m_pos / m_fdiv] : 1));
      check("R4 tx ready", bus_rdata[6], !m_hold);
      check("R4 tx empty", bus_rdata[5], !m_hold && !m_busy);
      check("R5 tx overrun", bus_rdata[4], m_toe);
    end
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 3'd2;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1;
    #1 d = int'(bus_rdata);
    @(posedge clk); #1;
    bus_rd = 0; bus_addr = 3'd2;
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stopv);
    logic [9:0] f;
    f = {stopv, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (bdiv) @(negedge clk);
    end
    repeat (2 * bdiv + 4) @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 3'd2; bus_wdata = '0;
    rxd = 1; cts_in = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    // R1 reset state
    check("R1 status", int'(bus_rdata), 'h60);
    check("R1 irq", irq, 0);
    check("R1 txd", txd, 1);
    check("R1 rts", rts_out, 0);
    bus_read(3, v); check("R1 control", v, 0);
    bus_read(4, v); check("R1 divisor reset", v, 10);
    cmp_on = 1;

    // R2 / R14 register read-back and RTS
    bus_write(3, 'h0800); wait_clk(1);
    check("R14 rts high", rts_out, 1);
    bus_read(3, v); check("R2 control", v, 'h0800);
    bus_write(4, 6); bdiv = 6;
    bus_read(4, v); check("R2 divisor", v, 6);
    bus_write(5, 'h5A);
    bus_read(5, v); check("R2 pkt end", v, 'h5A);
    bus_write(3, 0); wait_clk(1);
    check("R14 rts low", rts_out, 0);

    // R3 / R4 single frame
    bus_write(1, 'hA5);
    wait_clk(70);
    bus_read(2, v); check("R4 idle ready+empty", v & 'h60, 'h60);

    // R5 overrun on a full slot
    bus_write(1, 'h3C);
    wait_clk(3);
    bus_write(1, 'hC3);
    bus_write(1, 'h99);
    wait_clk(2);
    bus_read(2, v); check("R5 overrun flag", (v >> 4) & 1, 1);
    check("R10 exception from toe", (v >> 8) & 1, 1);
    wait_clk(140);
    bus_write(2, 0);
    wait_clk(1);
    bus_read(2, v); check("R11 toe cleared", v & 'h11F, 0);

    // R6 break force
    bus_write(3, 'h0200); wait_clk(5);
    check("R6 break low", txd, 0);
    bus_write(3, 0); wait_clk(1);
    check("R6 break released", txd, 1);

    // R7 receive and read clears ready
    rx_frame(8'h96, 1'b1);
    bus_read(2, v); check("R7 rx ready", (v >> 7) & 1, 1);
    check("R9 no framing on good stop", (v >> 1) & 1, 0);
    bus_read(0, v); check("R7 rx data", v, 'h96);
    bus_read(2, v); check("R7 ready cleared", (v >> 7) & 1, 0);

    // R8 overrun on receive
    rx_frame(8'h11, 1'b1);
    rx_frame(8'h22, 1'b1);
    bus_read(2, v); check("R8 rx overrun", (v >> 3) & 1, 1);
    check("R10 exception from roe", (v >> 8) & 1, 1);
    bus_read(0, v); check("R8 newest byte kept", v, 'h22);

    // R11 clear keeps ready
    rx_frame(8'h44, 1'b1);
    bus_write(2, 0);
    bus_read(2, v); check("R11 errors cleared", v & 'h51F, 0);
    check("R11 rrdy untouched", (v >> 7) & 1, 1);
    bus_read(0, v); check("R7 data 44", v, 'h44);

    // R9 framing and break
    rx_frame(8'h55, 1'b0);
    bus_read(2, v); check("R9 framing", (v >> 1) & 1, 1);
    check("R9 no break on nonzero", (v >> 2) & 1, 0);
    rxd = 1; wait_clk(4);
    bus_read(0, v);
    bus_write(2, 0);
    rx_frame(8'h00, 1'b0);
    bus_read(2, v); check("R9 break", (v >> 2) & 1, 1);
    check("R9 framing on break", (v >> 1) & 1, 1);
    rxd = 1; wait_clk(4);
    bus_read(0, v);
    bus_write(2, 0);

    // R12 CTS
    cts_in = 1; wait_clk(1);
    check("R12 sync delay", (int'(bus_rdata) >> 11) & 1, 0);
    wait_clk(4);
    check("R12 cts level", (int'(bus_rdata) >> 11) & 1, 1);
    check("R12 change set on rise", (int'(bus_rdata) >> 10) & 1, 1);
    bus_write(2, 0); wait_clk(1);
    check("R12 change cleared", (int'(bus_rdata) >> 10) & 1, 0);
    cts_in = 0; wait_clk(5);
    check("R12 change set on fall", (int'(bus_rdata) >> 10) & 1, 1);

    // R13 interrupt enables
    bus_write(3, 'h0A00); wait_clk(1);
    check("R13 break/rts bits no irq", irq, 0);
    bus_write(3, 'h0400); wait_clk(1);
    check("R13 cts change irq", irq, 1);
    bus_write(2, 0); wait_clk(1);
    check("R13 irq drops after clear", irq, 0);
    bus_write(3, 'h0040); wait_clk(1);
    check("R13 tx ready irq", irq, 1);
    bus_write(3, 'h0080); wait_clk(1);
    check("R13 rx ready irq idle", irq, 0);
    rx_frame(8'h7E, 1'b1);
    check("R13 rx ready irq", irq, 1);
    bus_read(0, v); wait_clk(1);
    check("R13 irq after read", irq, 0);
    bus_write(3, 0);
    wait_clk(10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule